// File: doc/BRIEF.md
# Address Register File with Effective-Address Unit

This block keeps eight 32-bit address registers for a processor core and turns each memory-operand request into an effective address. Register 7 is the stack pointer. It has two physical copies, one used at user privilege and one at supervisor privilege, and the `supervisor` input picks the copy. Every other register has a single copy. An operand request names a base register, an addressing mode, an operand size, a displacement and an index value. The block returns the full 32-bit effective address, the 24-bit physical address driven towards the pins, and an address-error flag. In the auto-modify modes it also writes the moved pointer back into the register file.

Requests come in on a valid/ready channel (`op_valid`/`op_ready`). A request is accepted on a rising edge where both are high. Its write-back is committed on that same edge, and its result appears on the result channel (`res_valid`/`res_ready`) in the following cycle. A result that the consumer has not taken stays unchanged on the outputs. While a result is held, `op_ready` stays low, so no register is modified while the consumer applies back-pressure. A plain register load (`wr_en`) takes priority over a request: `op_ready` is low in any cycle where `wr_en` is high, so at most one register changes per cycle.

Top module: `areg_agu`

## Requirements
- R1: After reset, `res_valid` is 0 and every address register, both stack-pointer copies included, reads as 0.
- R2: In plain indirect mode (`op_mode` 0), the effective address is the base register value and no register changes. Codes 5 to 7 behave as plain.
- R3: In post-increment mode (`op_mode` 1), the effective address is the base register value. On acceptance the register advances by 1, 2 or 4 for `op_size` 0 (byte), 1 (word) or 2 (long). Size code 3 acts as long.
- R4: In pre-decrement mode (`op_mode` 2), the register is reduced by the size step, and the reduced value is both the effective address and the new register contents.
- R5: When the base register is 7, a byte-size increment or decrement moves the pointer by 2 instead of 1.
- R6: Register 7 reads and writes the supervisor copy when `supervisor` is 1 and the user copy when it is 0. The other copy is untouched.
- R7: In displacement mode (`op_mode` 3), the effective address is the base register plus the sign-extended 16-bit `op_disp`. No register changes.
- R8: In indexed mode (`op_mode` 4), the effective address is the base register plus the sign-extended `op_disp[7:0]` plus the index. The index is `op_index` in full when `op_index_long` is 1, and the sign-extended `op_index[15:0]` when it is 0. No register changes.
- R9: All address arithmetic wraps modulo 2^32. `res_addr` carries bits 23:0 of `res_ea`.
- R10: A word or long request whose effective address is odd returns `res_addr_err` = 1 and leaves the base register unchanged. A byte request never sets the flag.
- R11: `op_ready` equals (`res_valid` = 0 or `res_ready` = 1) and `wr_en` = 0. A result appears the cycle after acceptance and holds its value while `res_ready` is low.
- R12: `wr_en` writes `wr_data` into register `wr_sel` on the next edge. Selector 7 writes the stack-pointer copy for the current privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Privilege state; picks the stack-pointer copy |
| wr_en | input | 1 | Load a register this cycle |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 32 | Value to load |
| op_valid | input | 1 | Operand request present |
| op_ready | output | 1 | Request can be accepted |
| op_reg | input | 3 | Base register |
| op_mode | input | 3 | Addressing mode code |
| op_size | input | 2 | Operand size code |
| op_disp | input | 16 | Displacement (low 8 bits in indexed mode) |
| op_index | input | 32 | Index register value |
| op_index_long | input | 1 | 1: full 32-bit index, 0: sign-extended low 16 bits |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_ea | output | 32 | Effective address |
| res_addr | output | 24 | Physical address |
| res_addr_err | output | 1 | Misaligned word or long access |

## Verification
The in-line assertions check the following on every cycle:
- a written value lands in its register;
- a supervisor stack-pointer write leaves the user copy alone;
- a misaligned request never reaches the write port;
- pre-decrement writes back the same value it returns;
- post-increment returns the old base;
- a stalled result neither drops nor changes.

Only the bench scenarios can show the arithmetic itself, and only in sequences of requests that carry state from one to the next. These cover the size-dependent steps, the stack-pointer step of 2, 32-bit wrap and truncation to 24 bits, both index widths, and that an address error leaves the pointer where it was.

// File: rtl/areg_pkg.sv
package areg_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_INDEX   = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } osize_e;
endpackage

// File: rtl/areg_bank.sv
module areg_bank #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup,
  input  logic [SELW-1:0] rd_sel,
  output logic [AW-1:0]   rd_data,
  input  logic            we,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data
);
  localparam int NGP = NREG - 1;
  localparam logic [SELW-1:0] SP_SEL = SELW'(NREG - 1);

  logic [AW-1:0] gp [NGP];
  logic [AW-1:0] usp_q, ssp_q;

  for (genvar i = 0; i < NGP; i++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rst_n)                             gp[i] <= '0;
      else if (we && wr_sel == SELW'(i))      gp[i] <= wr_data;
    end

    // R12: a write reaches the selected register on the next edge
    assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_sel == SELW'(i)) |=> (gp[i] == $past(wr_data)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usp_q <= '0;
      ssp_q <= '0;
    end else if (we && wr_sel == SP_SEL) begin
      if (sup) ssp_q <= wr_data;
      else     usp_q <= wr_data;
    end
  end

  always_comb begin
    if (rd_sel == SP_SEL) rd_data = sup ? ssp_q : usp_q;
    else                  rd_data = gp[rd_sel];
  end

  // R6: a supervisor stack write keeps the user copy
  assert_bank_user_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_sel == SP_SEL && sup) |=> $stable(usp_q));
  // R6: a user stack write keeps the supervisor copy
  assert_bank_sup_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_sel == SP_SEL && !sup) |=> $stable(ssp_q));
endmodule

// File: rtl/areg_ea.sv
module areg_ea
  import areg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SELW = 3,
  parameter int SP_SEL = 7
) (
  input  logic [AW-1:0]   base,
  input  logic [SELW-1:0] rsel,
  input  logic [2:0]      mode,
  input  logic [1:0]      size,
  input  logic [15:0]     disp,
  input  logic [AW-1:0]   idx,
  input  logic            idx_long,
  output logic [AW-1:0]   ea,
  output logic            wb_en,
  output logic [AW-1:0]   wb_val,
  output logic            misalign
);
  logic [AW-1:0] step, disp16_x, disp8_x, idx_x, moved;
  logic          is_sp, auto_mod;

  assign is_sp    = (rsel == SELW'(SP_SEL));
  assign disp16_x = {{(AW-16){disp[15]}}, disp};
  assign disp8_x  = {{(AW-8){disp[7]}}, disp[7:0]};
  assign idx_x    = idx_long ? idx : {{(AW-16){idx[15]}}, idx[15:0]};

  always_comb begin
    case (osize_e'(size))
      SZ_BYTE: step = is_sp ? AW'(2) : AW'(1);
      SZ_WORD: step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  always_comb begin
    ea       = base;
    moved    = base;
    auto_mod = 1'b0;
    case (amode_e'(mode))
      AM_POSTINC: begin
        moved    = base + step;
        auto_mod = 1'b1;
      end
      AM_PREDEC: begin
        moved    = base - step;
        ea       = moved;
        auto_mod = 1'b1;
      end
      AM_DISP:  ea = base + disp16_x;
      AM_INDEX: ea = base + disp8_x + idx_x;
      default:  ea = base;
    endcase
  end

  assign misalign = (osize_e'(size) != SZ_BYTE) && ea[0];
  assign wb_en    = auto_mod && !misalign;
  assign wb_val   = moved;
endmodule

// File: rtl/areg_out.sv
module areg_out #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_ea,
  input  logic          in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_ea,
  output logic          out_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ea    <= '0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_ea    <= in_ea;
      out_err   <= in_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: an untaken result is neither dropped nor changed
  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_err)));
endmodule

// File: rtl/areg_agu.sv
module areg_agu
  import areg_pkg::*;
#(
  parameter int AW   = 32,
  parameter int PAW  = 24,
  parameter int NREG = 8,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supervisor,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [SELW-1:0] op_reg,
  input  logic [2:0]      op_mode,
  input  logic [1:0]      op_size,
  input  logic [15:0]     op_disp,
  input  logic [AW-1:0]   op_index,
  input  logic            op_index_long,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_ea,
  output logic [PAW-1:0]  res_addr,
  output logic            res_addr_err
);
  logic [AW-1:0]   base, ea, wb_val, bank_wdata;
  logic            wb_en, misalign, accept, bank_we;
  logic [SELW-1:0] bank_wsel;

  assign op_ready = (!res_valid || res_ready) && !wr_en;
  assign accept   = op_valid && op_ready;

  assign bank_we    = wr_en || (accept && wb_en);
  assign bank_wsel  = wr_en ? wr_sel  : op_reg;
  assign bank_wdata = wr_en ? wr_data : wb_val;

  areg_bank #(.AW(AW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .sup(supervisor),
    .rd_sel(op_reg), .rd_data(base),
    .we(bank_we), .wr_sel(bank_wsel), .wr_data(bank_wdata)
  );

  areg_ea #(.AW(AW), .SELW(SELW), .SP_SEL(NREG - 1)) u_ea (
    .base(base), .rsel(op_reg), .mode(op_mode), .size(op_size),
    .disp(op_disp), .idx(op_index), .idx_long(op_index_long),
    .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .misalign(misalign)
  );

  areg_out #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .in_ea(ea), .in_err(misalign),
    .out_valid(res_valid), .out_ready(res_ready), .out_ea(res_ea), .out_err(res_addr_err)
  );

  assign res_addr = res_ea[PAW-1:0];

  // R10: a misaligned request never writes the register file
  assert_err_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misalign) |-> !bank_we);
  // R4: pre-decrement writes back the address it returns
  assert_predec_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_mode == AM_PREDEC && !misalign) |-> (bank_we && bank_wdata == ea));
  // R3: post-increment returns the old base value
  assert_postinc_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_mode == AM_POSTINC) |=> (res_valid && res_ea == $past(base)));
endmodule

// File: tb/tb_areg_agu.sv
module tb_areg_agu;
  logic        clk = 1'b0;
  logic        rst_n, supervisor, wr_en, op_valid, op_ready, op_index_long;
  logic        res_valid, res_ready, res_addr_err;
  logic [2:0]  wr_sel, op_reg, op_mode;
  logic [1:0]  op_size;
  logic [15:0] op_disp;
  logic [31:0] wr_data, op_index, res_ea;
  logic [23:0] res_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  areg_agu dut (
    .clk(clk), .rst_n(rst_n), .supervisor(supervisor),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op_valid(op_valid), .op_ready(op_ready), .op_reg(op_reg), .op_mode(op_mode),
    .op_size(op_size), .op_disp(op_disp), .op_index(op_index),
    .op_index_long(op_index_long), .res_valid(res_valid), .res_ready(res_ready),
    .res_ea(res_ea), .res_addr(res_addr), .res_addr_err(res_addr_err)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        sup;
    logic [2:0]  rsel;
    logic [2:0]  mode;
    logic [1:0]  size;
    logic [15:0] disp;
    logic [31:0] idx;
    logic        il;
    logic [31:0] ea;
    logic        err;
  } vec_t;

  localparam int NV = 23;
  // Start state: A0=1000 A1=2001 A3=FFFFFFF0 A4=12345678 USP=800 SSP=4000
  localparam vec_t VECS [NV] = '{
    '{8'd2,  1'b0, 3'd0, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00001000, 1'b0}, // R2
    '{8'd3,  1'b0, 3'd0, 3'd1, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00001000, 1'b0}, // R3 A0->1001
    '{8'd10, 1'b0, 3'd0, 3'd1, 2'd1, 16'h0000, 32'h0, 1'b0, 32'h00001001, 1'b1}, // R10 odd word
    '{8'd10, 1'b0, 3'd0, 3'd1, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00001001, 1'b0}, // R10 unchanged
    '{8'd3,  1'b0, 3'd0, 3'd1, 2'd2, 16'h0000, 32'h0, 1'b0, 32'h00001002, 1'b0}, // R3 A0->1006
    '{8'd4,  1'b0, 3'd0, 3'd2, 2'd1, 16'h0000, 32'h0, 1'b0, 32'h00001004, 1'b0}, // R4 word
    '{8'd4,  1'b0, 3'd0, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00001004, 1'b0}, // R4 kept
    '{8'd4,  1'b0, 3'd0, 3'd2, 2'd2, 16'h0000, 32'h0, 1'b0, 32'h00001000, 1'b0}, // R4 long
    '{8'd7,  1'b0, 3'd1, 3'd3, 2'd0, 16'hFFFF, 32'h0, 1'b0, 32'h00002000, 1'b0}, // R7 neg
    '{8'd7,  1'b0, 3'd1, 3'd3, 2'd1, 16'h0011, 32'h0, 1'b0, 32'h00002012, 1'b0}, // R7 pos
    '{8'd7,  1'b0, 3'd1, 3'd6, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00002001, 1'b0}, // R7 no wb, R2 code 6
    '{8'd8,  1'b0, 3'd1, 3'd4, 2'd0, 16'h0080, 32'h00018000, 1'b0, 32'hFFFF9F81, 1'b0}, // R8 short
    '{8'd8,  1'b0, 3'd1, 3'd4, 2'd1, 16'h0005, 32'h00018000, 1'b1, 32'h0001A006, 1'b0}, // R8 long
    '{8'd9,  1'b0, 3'd3, 3'd3, 2'd0, 16'h0020, 32'h0, 1'b0, 32'h00000010, 1'b0}, // R9 wrap
    '{8'd9,  1'b0, 3'd4, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h12345678, 1'b0}, // R9 high byte
    '{8'd5,  1'b0, 3'd7, 3'd1, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00000800, 1'b0}, // R5 USP->802
    '{8'd6,  1'b1, 3'd7, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00004000, 1'b0}, // R6 SSP
    '{8'd5,  1'b1, 3'd7, 3'd2, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00003FFE, 1'b0}, // R5 SSP->3FFE
    '{8'd6,  1'b0, 3'd7, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00000802, 1'b0}, // R6 USP
    '{8'd6,  1'b1, 3'd7, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'h00003FFE, 1'b0}, // R6 SSP
    '{8'd9,  1'b0, 3'd2, 3'd2, 2'd0, 16'h0000, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b0}, // R9 from 0
    '{8'd9,  1'b0, 3'd5, 3'd2, 2'd3, 16'h0000, 32'h0, 1'b0, 32'hFFFFFFFC, 1'b0}, // R9 size 3 long
    '{8'd3,  1'b0, 3'd5, 3'd0, 2'd0, 16'h0000, 32'h0, 1'b0, 32'hFFFFFFFC, 1'b0}  // R3 kept
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic load(input logic sup, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    supervisor = sup; wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_op(input logic sup, input logic [2:0] rs, input logic [2:0] md,
                        input logic [1:0] sz, input logic [15:0] dp, input logic [31:0] ix,
                        input logic il, output logic [31:0] ea, output logic err,
                        output logic [23:0] pa);
    @(negedge clk);
    supervisor = sup; op_reg = rs; op_mode = md; op_size = sz;
    op_disp = dp; op_index = ix; op_index_long = il; op_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    ea = res_ea; err = res_addr_err; pa = res_addr;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] ea;
    logic [23:0] pa;
    logic        err;
    rst_n = 1'b0; supervisor = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    op_valid = 1'b0; op_reg = '0; op_mode = '0; op_size = '0; op_disp = '0;
    op_index = '0; op_index_long = 1'b0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 res_valid in reset", {31'b0, res_valid}, 32'd0);
    rst_n = 1'b1;

    // R1: untouched registers and both stack copies read zero
    run_op(1'b0, 3'd6, 3'd0, 2'd0, 16'h0, 32'h0, 1'b0, ea, err, pa);
    check("R1 A6 after reset", ea, 32'h0);
    run_op(1'b0, 3'd7, 3'd0, 2'd0, 16'h0, 32'h0, 1'b0, ea, err, pa);
    check("R1 USP after reset", ea, 32'h0);
    run_op(1'b1, 3'd7, 3'd0, 2'd0, 16'h0, 32'h0, 1'b0, ea, err, pa);
    check("R1 SSP after reset", ea, 32'h0);

    // R12: loads, selector 7 by privilege
    load(1'b0, 3'd0, 32'h00001000);
    load(1'b0, 3'd1, 32'h00002001);
    load(1'b0, 3'd3, 32'hFFFFFFF0);
    load(1'b0, 3'd4, 32'h12345678);
    load(1'b0, 3'd7, 32'h00000800);
    load(1'b1, 3'd7, 32'h00004000);
    load(1'b0, 3'd6, 32'hCAFE0000);
    run_op(1'b0, 3'd6, 3'd0, 2'd0, 16'h0, 32'h0, 1'b0, ea, err, pa);
    check("R12 load A6", ea, 32'hCAFE0000);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].sup, VECS[i].rsel, VECS[i].mode, VECS[i].size, VECS[i].disp,
             VECS[i].idx, VECS[i].il, ea, err, pa);
      check($sformatf("R%0d vec %0d ea", VECS[i].req, i), ea, VECS[i].ea);
      check($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, err}, {31'b0, VECS[i].err});
      check($sformatf("R9 vec %0d pin addr", i), {8'b0, pa}, {8'b0, VECS[i].ea[23:0]});
    end

    // R11: wr_en blocks requests
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'hCAFE0000; op_valid = 1'b1;
    op_reg = 3'd0; op_mode = 3'd0; res_ready = 1'b1;
    #0.5;
    check("R11 op_ready low during wr_en", {31'b0, op_ready}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0;
    check("R11 no result while loading", {31'b0, res_valid}, 32'd0);

    // R11: back-pressure holds the result and stalls the next request
    @(negedge clk);
    supervisor = 1'b0; op_reg = 3'd0; op_mode = 3'd1; op_size = 2'd2;
    op_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    check("R11 first result", res_ea, 32'h00001000);
    check("R11 op_ready low while held", {31'b0, op_ready}, 32'd0);
    op_reg = 3'd0; op_mode = 3'd0;
    repeat (3) @(negedge clk);
    check("R11 result held", res_ea, 32'h00001000);
    check("R11 valid held", {31'b0, res_valid}, 32'd1);
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 second result after release", res_ea, 32'h00001004);
    @(negedge clk);
    check("R11 drained", {31'b0, res_valid}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule